// File: doc/BRIEF.md
# Two-Phase Processor Bus Sequencer and Address Decoder

This block sits between an 8-bit processor core and the memory-mapped devices of a small game console. It divides one system clock into alternating bus phases. The first phase gives devices time to decode the address, and the second phase is the only time anyone may drive the shared data bus. At the start of each phase one, the block registers the core's 16-bit address, read/write line and write data. It decodes that address against a sparse console memory map into one-hot device selects.

The block also controls the data pad. The pad is modelled as separate input, output and output-enable signals. The block derives the active-low RAM write strobe and returns read data to the core. Read data is held in a register. A read from an address that no device claims returns the last byte seen on the bus.

Top module: `cpu_bus_sequencer`

## Requirements
- R1: While reset is asserted: `phi1_o`=1, `phi2_o`=0, `bus_addr`=0x0000, `bus_rw`=1, `dbus_oe`=0, `ram_we_n`=1 and `core_rdata`=0x00.
- R2: After reset is released, the phases alternate on every clock edge. Phase one lasts one clock and phase two the next, and `phi1_o` is always the inverse of `phi2_o`.
- R3: `bus_addr` and `bus_rw` take the core's `core_addr` and `core_rw` only at the edge that begins phase one. A change to the core inputs during a bus cycle has no effect on these outputs until the next phase one.
- R4: Selects decode `bus_addr` as follows:
  - `sel_ram` for 0x0000–0x07FF
  - `sel_picu` for 0x2000–0x2007
  - `sel_sndio` for 0x4000–0x4016
  - `sel_exp` for 0x5000–0x5FFF
  - `sel_rom` for 0x8000–0xFFFF
- R5: An address outside every window (for example 0x0800, 0x1FFF, 0x2008, 0x4017, 0x4FFF, 0x6000, 0x7FFF) asserts no select.
- R6: At most one select is active at any time.
- R7: `dbus_oe` is 1 only during phase two of a write cycle (`bus_rw`=0). While it is 1, `dbus_out` equals the write data latched with the address.
- R8: `ram_we_n` is 0 only during phase two when `bus_rw`=0 and `sel_ram`=1. Otherwise it is 1.
- R9: On a read with a select active, `dbus_in` is sampled at the end of phase two. `core_rdata` shows that value from the following phase one.
- R10: On a read where no select is active, `core_rdata` keeps its previous value (open bus).
- R11: After a write cycle, to any address, `core_rdata` equals the byte that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, two edges per bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_addr | input | 16 | Address from processor core |
| core_rw | input | 1 | Read (1) / write (0) from core |
| core_wdata | input | 8 | Write data from core |
| core_rdata | output | 8 | Held read data back to core |
| phi1_o | output | 1 | High during phase one |
| phi2_o | output | 1 | High during phase two |
| bus_addr | output | 16 | Registered address bus |
| bus_rw | output | 1 | Registered read/write line |
| dbus_in | input | 8 | Data pad input |
| dbus_out | output | 8 | Data pad output value |
| dbus_oe | output | 1 | Data pad output enable |
| ram_we_n | output | 1 | Active-low RAM write strobe |
| sel_ram | output | 1 | System RAM select |
| sel_picu | output | 1 | Picture-unit register window select |
| sel_sndio | output | 1 | Audio/controller register window select |
| sel_exp | output | 1 | Expansion window select |
| sel_rom | output | 1 | Program ROM select |

## Verification
A phase register that is stuck or skips a state shows within two clocks: the bus enables appear in phase one or are never released. A wrong window bound shows in the same phase one as the bad address, as a missing select or as two selects at once. A corrupt open-bus hold register shows in the phase one right after the cycle that should have refreshed or kept it. The bench therefore compares selects and pad controls in both phases of every cycle, and compares read data at each following phase one.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
  localparam int NUM_WIN = 5;

  typedef enum logic [2:0] {
    WIN_RAM   = 3'd0,
    WIN_PICU  = 3'd1,
    WIN_SNDIO = 3'd2,
    WIN_EXP   = 3'd3,
    WIN_ROM   = 3'd4
  } win_e;

  // lower bound of each decode window
  function automatic logic [15:0] win_lo(input int idx);
    case (idx)
      0:       return 16'h0000;
      1:       return 16'h2000;
      2:       return 16'h4000;
      3:       return 16'h5000;
      default: return 16'h8000;
    endcase
  endfunction

  // upper bound (inclusive) of each decode window
  function automatic logic [15:0] win_hi(input int idx);
    case (idx)
      0:       return 16'h07FF;
      1:       return 16'h2007;
      2:       return 16'h4016;
      3:       return 16'h5FFF;
      default: return 16'hFFFF;
    endcase
  endfunction
endpackage

// File: rtl/cbd_phase_seq.sv
module cbd_phase_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic              core_rw,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              ph2,
  output logic [ADDR_W-1:0] addr_q,
  output logic              rw_q,
  output logic [DATA_W-1:0] wdata_q
);
  logic              ph_d;
  logic              ld_en;
  logic [ADDR_W-1:0] addr_d;
  logic              rw_d;
  logic [DATA_W-1:0] wdata_d;

  // load happens on the edge that ends phase two / starts phase one
  assign ld_en = ph2;

  always_comb begin
    ph_d    = ~ph2;
    addr_d  = addr_q;
    rw_d    = rw_q;
    wdata_d = wdata_q;
    if (ld_en) begin
      addr_d  = core_addr;
      rw_d    = core_rw;
      wdata_d = core_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph2     <= 1'b0;
      addr_q  <= '0;
      rw_q    <= 1'b1;
      wdata_q <= '0;
    end else begin
      ph2     <= ph_d;
      addr_q  <= addr_d;
      rw_q    <= rw_d;
      wdata_q <= wdata_d;
    end
  end
endmodule

// File: rtl/cbd_addr_decode.sv
module cbd_addr_decode
  import cbd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_WIN-1:0] sel,
  output logic               any_sel
);
  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(win_lo(gi));
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(win_hi(gi));
    assign sel[gi] = (addr >= LO) && (addr <= HI);
  end

  assign any_sel = |sel;
endmodule

// File: rtl/cbd_data_path.sv
module cbd_data_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ph2,
  input  logic              rw_q,
  input  logic              any_sel,
  input  logic              ram_sel,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic [DATA_W-1:0] dbus_in,
  output logic [DATA_W-1:0] dbus_out,
  output logic              dbus_oe,
  output logic              ram_we_n,
  output logic [DATA_W-1:0] rdata
);
  logic              cap_en;
  logic [DATA_W-1:0] hold_d;

  // core drives pad only in phase two of a write
  assign dbus_oe  = ph2 & ~rw_q;
  assign dbus_out = wdata_q;
  assign ram_we_n = ~(ph2 & ~rw_q & ram_sel);

  // capture at the edge that closes phase two
  assign cap_en = ph2;

  always_comb begin
    hold_d = rdata;
    if (cap_en) begin
      if (!rw_q)        hold_d = wdata_q;
      else if (any_sel) hold_d = dbus_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= hold_d;
  end
endmodule

// File: rtl/cpu_bus_sequencer.sv
module cpu_bus_sequencer
  import cbd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic              core_rw,
  input  logic [DATA_W-1:0] core_wdata,
  output logic [DATA_W-1:0] core_rdata,
  output logic              phi1_o,
  output logic              phi2_o,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rw,
  input  logic [DATA_W-1:0] dbus_in,
  output logic [DATA_W-1:0] dbus_out,
  output logic              dbus_oe,
  output logic              ram_we_n,
  output logic              sel_ram,
  output logic              sel_picu,
  output logic              sel_sndio,
  output logic              sel_exp,
  output logic              sel_rom
);
  logic               rst_meta_n;
  logic               rst_int_n;
  logic               ph2;
  logic [DATA_W-1:0]  wdata_q;
  logic [NUM_WIN-1:0] sel;
  logic               any_sel;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_int_n  <= rst_meta_n;
    end
  end

  cbd_phase_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .core_addr  (core_addr),
    .core_rw    (core_rw),
    .core_wdata (core_wdata),
    .ph2        (ph2),
    .addr_q     (bus_addr),
    .rw_q       (bus_rw),
    .wdata_q    (wdata_q)
  );

  cbd_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (bus_addr),
    .sel     (sel),
    .any_sel (any_sel)
  );

  cbd_data_path #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ph2      (ph2),
    .rw_q     (bus_rw),
    .any_sel  (any_sel),
    .ram_sel  (sel[WIN_RAM]),
    .wdata_q  (wdata_q),
    .dbus_in  (dbus_in),
    .dbus_out (dbus_out),
    .dbus_oe  (dbus_oe),
    .ram_we_n (ram_we_n),
    .rdata    (core_rdata)
  );

  assign phi2_o    = ph2;
  assign phi1_o    = ~ph2;
  assign sel_ram   = sel[WIN_RAM];
  assign sel_picu  = sel[WIN_PICU];
  assign sel_sndio = sel[WIN_SNDIO];
  assign sel_exp   = sel[WIN_EXP];
  assign sel_rom   = sel[WIN_ROM];
endmodule

// File: rtl/cbd_chk.sv
module cbd_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              phi1_o,
  input logic              phi2_o,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rw,
  input logic              dbus_oe,
  input logic              ram_we_n,
  input logic [DATA_W-1:0] core_rdata,
  input logic [4:0]        sels
);
  // R2
  phase_alt_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    phi1_o |=> phi2_o);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    phi2_o |-> ($stable(bus_addr) && $stable(bus_rw)));

  // R6
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(sels));

  // R7
  oe_phase_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    dbus_oe |-> (phi2_o && !bus_rw));

  // R8
  ram_we_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ram_we_n |-> (phi2_o && !bus_rw && sels[0]));

  // R10
  open_bus_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (phi1_o && $past(phi2_o) && $past(bus_rw) && ($past(sels) == 5'd0))
      |-> (core_rdata == $past(core_rdata)));
endmodule

bind cpu_bus_sequencer cbd_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_int_n  (rst_int_n),
  .phi1_o     (phi1_o),
  .phi2_o     (phi2_o),
  .bus_addr   (bus_addr),
  .bus_rw     (bus_rw),
  .dbus_oe    (dbus_oe),
  .ram_we_n   (ram_we_n),
  .core_rdata (core_rdata),
  .sels       ({sel_rom, sel_exp, sel_sndio, sel_picu, sel_ram})
);

// File: tb/tb_cpu_bus_sequencer.sv
module tb_cpu_bus_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] core_addr = 16'h0;
  logic        core_rw = 1'b1;
  logic [7:0]  core_wdata = 8'h0;
  logic [7:0]  core_rdata;
  logic        phi1_o, phi2_o;
  logic [15:0] bus_addr;
  logic        bus_rw;
  logic [7:0]  dbus_in = 8'h0;
  logic [7:0]  dbus_out;
  logic        dbus_oe, ram_we_n;
  logic        sel_ram, sel_picu, sel_sndio, sel_exp, sel_rom;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [7:0] model_hold = 8'h00;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  cpu_bus_sequencer dut (
    .clk(clk), .rst_n(rst_n), .core_addr(core_addr), .core_rw(core_rw),
    .core_wdata(core_wdata), .core_rdata(core_rdata), .phi1_o(phi1_o),
    .phi2_o(phi2_o), .bus_addr(bus_addr), .bus_rw(bus_rw), .dbus_in(dbus_in),
    .dbus_out(dbus_out), .dbus_oe(dbus_oe), .ram_we_n(ram_we_n),
    .sel_ram(sel_ram), .sel_picu(sel_picu), .sel_sndio(sel_sndio),
    .sel_exp(sel_exp), .sel_rom(sel_rom)
  );

  function automatic logic [4:0] exp_sel(input logic [15:0] a);
    logic [4:0] s;
    s[0] = (a <= 16'h07FF);
    s[1] = (a >= 16'h2000) && (a <= 16'h2007);
    s[2] = (a >= 16'h4000) && (a <= 16'h4016);
    s[3] = (a >= 16'h5000) && (a <= 16'h5FFF);
    s[4] = (a >= 16'h8000);
    return s;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: entered at a negedge in phase two
  task automatic run_cycle(input logic [15:0] a, input logic rw,
                           input logic [7:0] wd, input logic [7:0] din);
    logic [4:0] es;
    es = exp_sel(a);
    core_addr = a; core_rw = rw; core_wdata = wd;
    @(negedge clk); // phase one
    check("R2 phi1 in phase one", {31'd0, phi1_o}, 32'd1);
    check("R3 bus_addr latched", {16'd0, bus_addr}, {16'd0, a});
    check("R3 bus_rw latched", {31'd0, bus_rw}, {31'd0, rw});
    check((es == 0) ? "R5 no select" : "R4 select decode",
          {27'd0, sel_rom, sel_exp, sel_sndio, sel_picu, sel_ram}, {27'd0, es});
    check("R6 select count", $countones({sel_rom, sel_exp, sel_sndio, sel_picu, sel_ram}),
          (es == 0) ? 32'd0 : 32'd1);
    check("R7 oe low in phase one", {31'd0, dbus_oe}, 32'd0);
    check("R8 we high in phase one", {31'd0, ram_we_n}, 32'd1);
    core_addr = ~a; core_rw = ~rw; // mid-cycle change must not reach bus
    @(negedge clk); // phase two
    dbus_in = din;
    check("R2 phi2 in phase two", {31'd0, phi2_o}, 32'd1);
    check("R3 bus_addr stable", {16'd0, bus_addr}, {16'd0, a});
    check("R3 bus_rw stable", {31'd0, bus_rw}, {31'd0, rw});
    check("R7 oe in phase two", {31'd0, dbus_oe}, {31'd0, ~rw});
    if (!rw) check("R7 dbus_out data", {24'd0, dbus_out}, {24'd0, wd});
    check("R8 ram_we_n", {31'd0, ram_we_n}, {31'd0, ~(~rw & es[0])});
    if (!rw) begin model_hold = wd; tag_q.push_back("R11 write hold"); end
    else if (es != 0) begin model_hold = din; tag_q.push_back("R9 read capture"); end
    else tag_q.push_back("R10 open bus");
    exp_q.push_back(model_hold);
  endtask

  // monitor: compare held read data at each phase one
  always @(negedge clk) begin
    if (rst_n && phi1_o && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {24'd0, core_rdata}, {24'd0, e});
    end
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic prev;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 phi1", {31'd0, phi1_o}, 32'd1);
    check("R1 phi2", {31'd0, phi2_o}, 32'd0);
    check("R1 bus_addr", {16'd0, bus_addr}, 32'd0);
    check("R1 bus_rw", {31'd0, bus_rw}, 32'd1);
    check("R1 dbus_oe", {31'd0, dbus_oe}, 32'd0);
    check("R1 ram_we_n", {31'd0, ram_we_n}, 32'd1);
    check("R1 core_rdata", {24'd0, core_rdata}, 32'd0);
    rst_n = 1'b1;
    do @(negedge clk); while (!phi2_o);
    prev = phi1_o;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R2 alternation", {31'd0, phi1_o}, {31'd0, ~prev});
      check("R2 complement", {31'd0, phi1_o ^ phi2_o}, 32'd1);
      prev = phi1_o;
    end
    // now at negedge in phase two
    begin
      logic [15:0] sweep [18] = '{16'h0000, 16'h07FF, 16'h0800, 16'h1FFF, 16'h2000,
        16'h2007, 16'h2008, 16'h3FFF, 16'h4000, 16'h4016, 16'h4017, 16'h4FFF,
        16'h5000, 16'h5FFF, 16'h6000, 16'h7FFF, 16'h8000, 16'hFFFF};
      foreach (sweep[i]) run_cycle(sweep[i], 1'b1, 8'h00, sweep[i][7:0] ^ 8'h5A);
    end
    run_cycle(16'h0123, 1'b0, 8'hA5, 8'hEE); // RAM write
    run_cycle(16'h2003, 1'b0, 8'h3C, 8'hEE); // register write, no RAM strobe
    run_cycle(16'h0800, 1'b1, 8'h00, 8'h11); // open bus keeps 3C
    run_cycle(16'h6000, 1'b1, 8'h00, 8'h22); // open bus keeps 3C
    run_cycle(16'h7000, 1'b0, 8'h99, 8'hEE); // unmapped write
    run_cycle(16'h4017, 1'b1, 8'h00, 8'h33); // open bus keeps 99
    run_cycle(16'hC000, 1'b1, 8'h00, 8'h77); // ROM read
    run_cycle(16'h07FF, 1'b0, 8'h0F, 8'hEE); // RAM top write
    run_cycle(16'h5000, 1'b1, 8'h00, 8'h44); // expansion read
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule